// File: doc/BRIEF.md
# UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single transmit line. Each frame opens with a low start bit and carries 7 or 8 character bits, least significant first. An optional parity bit follows, then one or two high stop bits. A 2-bit frame-mode field chooses the character length and the stop count. A 3-bit parity field chooses one of these: no parity bit, a constant 0, a constant 1, odd parity or even parity. A break control turns the whole frame slot into a low level of the same length.

Bit timing comes from outside the block. A one-cycle `bit_tick` pulse marks each bit boundary, so the block holds no baud divider. A character enters through a valid/ready handshake. When a byte is accepted, the block also captures the mode, parity and break settings. After that the byte and its settings no longer depend on the inputs. The first bit begins at the first tick after acceptance, and `busy` stays high until the tick that closes the last stop bit.

Top module: `async_frame_tx`

## Requirements
- R1: `frame_mode[1]` picks the character length (0 gives 7 bits, 1 gives 8 bits). `frame_mode[0]` picks the stop count (0 gives one stop bit, 1 gives two).
- R2: The line idles high. A frame sends a 0 start bit, then the character bits least significant first, then the parity bit if present, then stop bits that are 1.
- R3: With 7-bit characters, bit 7 of `in_data` is never sent and has no effect on the parity bit.
- R4: When `parity_mode[2]` is 1, no parity bit goes out, whatever `parity_mode[1:0]` holds.
- R5: When `parity_mode[2]` is 0, `parity_mode[1:0]` = 00 sends a parity bit of 0 and 01 sends a parity bit of 1.
- R6: `parity_mode[1:0]` = 10 gives odd parity: the character bits and the parity bit together hold an odd number of ones.
- R7: `parity_mode[1:0]` = 11 gives even parity: the character bits and the parity bit together hold an even number of ones.
- R8: When `break_en` is 1 at acceptance, every bit slot from the start bit through the last stop bit is driven 0. The frame keeps the length it would have had without break.
- R9: Each bit is held for exactly one tick period. The start bit appears in the cycle after the first `bit_tick` that follows acceptance. After that, `tx` changes only in the cycle after a tick.
- R10: `in_ready` equals the inverse of `busy`. `busy` rises in the cycle after acceptance and stays high through the final stop bit.
- R11: The byte and the mode, parity and break settings are captured at acceptance. Changes to those inputs during the frame have no effect on it.
- R12: The tick that ends the last stop bit returns `tx` high and clears `busy` in the following cycle, so a new byte can be accepted in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle pulse marking each bit boundary |
| in_valid | input | 1 | A character is offered |
| in_data | input | 8 | Character to send, bit 0 goes out first |
| in_ready | output | 1 | Block can accept a character |
| frame_mode | input | 2 | [1]: 8-bit character, [0]: two stop bits |
| parity_mode | input | 3 | [2]: no parity; [1:0]: 00 zero, 01 one, 10 odd, 11 even |
| break_en | input | 1 | Drive the whole frame slot low |
| busy | output | 1 | A frame is pending or being sent |
| tx | output | 1 | Serial line |

## Verification
The bench keeps the block's package constants at their defaults, which give an 8-bit maximum character and a 12-slot maximum frame. It drives `bit_tick` once every 3 clocks. With that short tick period, the bench can send every frame mode combined with every parity setting, for several bytes, and add break frames, all well inside the cycle budget. After each acceptance, the bench inverts every setting input and the byte. This exposes any setting that is read live during a frame instead of at capture. Because frames are sent back to back, the one-cycle turnaround between frames is exercised on every frame.

// File: rtl/async_frame_tx_pkg.sv
package async_frame_tx_pkg;

  // widest character; the short character is one bit narrower
  localparam int unsigned CHAR_MAX  = 8;
  // start + widest character + parity + two stops
  localparam int unsigned FRAME_MAX = CHAR_MAX + 4;
  localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic       long_char;  // 1: CHAR_MAX bits, 0: CHAR_MAX-1 bits
    logic       two_stop;   // 1: two stop bits
    logic       par_off;    // 1: no parity bit
    logic [1:0] par_sel;    // 00 zero, 01 one, 10 odd, 11 even
    logic       brk;        // whole slot low
  } frame_cfg_t;

  function automatic int unsigned char_bits(frame_cfg_t c);
    return c.long_char ? CHAR_MAX : CHAR_MAX - 1;
  endfunction

  function automatic logic [CNT_W-1:0] frame_len(frame_cfg_t c);
    int unsigned n;
    n = 1 + char_bits(c) + (c.par_off ? 0 : 1) + (c.two_stop ? 2 : 1);
    return CNT_W'(n);
  endfunction

  // character with the unused top bit cleared
  function automatic logic [CHAR_MAX-1:0] char_mask(frame_cfg_t c, logic [CHAR_MAX-1:0] d);
    logic [CHAR_MAX-1:0] m;
    m = d;
    if (!c.long_char) m[CHAR_MAX-1] = 1'b0;
    return m;
  endfunction

  function automatic logic parity_bit(frame_cfg_t c, logic [CHAR_MAX-1:0] d);
    logic [CHAR_MAX-1:0] m;
    logic p;
    m = char_mask(c, d);
    case (c.par_sel)
      2'b00:   p = 1'b0;
      2'b01:   p = 1'b1;
      2'b10:   p = ~(^m);
      default: p = ^m;
    endcase
    return p;
  endfunction

  // slot vector, bit 0 is sent first; slots past the payload are stop level
  function automatic logic [FRAME_MAX-1:0] build_frame(frame_cfg_t c, logic [CHAR_MAX-1:0] d);
    logic [CHAR_MAX:0] payload;
    logic p;
    p = parity_bit(c, d);
    if (c.long_char) begin
      payload = c.par_off ? {1'b1, d} : {p, d};
    end else begin
      payload = c.par_off ? {2'b11, d[CHAR_MAX-2:0]} : {1'b1, p, d[CHAR_MAX-2:0]};
    end
    if (c.brk) return '0;
    return {{(FRAME_MAX - CHAR_MAX - 2){1'b1}}, payload, 1'b0};
  endfunction

endpackage

// File: rtl/aft_cfg_capture.sv
module aft_cfg_capture
  import async_frame_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                accept,
  input  frame_cfg_t          cfg_in,
  input  logic [CHAR_MAX-1:0] data_in,
  output frame_cfg_t          cfg_q,
  output logic [CHAR_MAX-1:0] data_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      data_q <= '0;
    end else if (accept) begin
      cfg_q  <= cfg_in;
      data_q <= data_in;
    end
  end

endmodule

// File: rtl/aft_frame_build.sv
module aft_frame_build
  import async_frame_tx_pkg::*;
(
  input  frame_cfg_t           cfg,
  input  logic [CHAR_MAX-1:0]  data,
  output logic [FRAME_MAX-1:0] slots,
  output logic [CNT_W-1:0]     nslots
);

  always_comb begin
    slots  = build_frame(cfg, data);
    nslots = frame_len(cfg);
  end

endmodule

// File: rtl/aft_bit_seq.sv
module aft_bit_seq
  import async_frame_tx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 tick,
  input  logic [FRAME_MAX-1:0] slots,
  input  logic [CNT_W-1:0]     nslots,
  output logic                 busy,
  output logic                 sending,
  output logic                 tx
);

  typedef enum logic [1:0] {S_IDLE, S_ALIGN, S_SEND} seq_state_t;

  seq_state_t           st;
  logic [FRAME_MAX-1:0] sh;
  logic [CNT_W-1:0]     rem;
  logic                 tx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      sh   <= '1;
      rem  <= '0;
      tx_q <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_ALIGN;
        S_ALIGN: if (tick) begin
          tx_q <= slots[0];
          sh   <= {1'b1, slots[FRAME_MAX-1:1]};
          rem  <= nslots - CNT_W'(1);
          st   <= S_SEND;
        end
        S_SEND: if (tick) begin
          if (rem == '0) begin
            tx_q <= 1'b1;
            st   <= S_IDLE;
          end else begin
            tx_q <= sh[0];
            sh   <= {1'b1, sh[FRAME_MAX-1:1]};
            rem  <= rem - CNT_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy    = (st != S_IDLE);
  assign sending = (st == S_SEND);
  assign tx      = tx_q;

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import async_frame_tx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                in_valid,
  input  logic [CHAR_MAX-1:0] in_data,
  output logic                in_ready,
  input  logic [1:0]          frame_mode,
  input  logic [2:0]          parity_mode,
  input  logic                break_en,
  output logic                busy,
  output logic                tx
);

  frame_cfg_t           cfg_in;
  frame_cfg_t           cfg_q;
  logic [CHAR_MAX-1:0]  data_q;
  logic [FRAME_MAX-1:0] slots;
  logic [CNT_W-1:0]     nslots;
  logic                 accept;
  logic                 sending;

  always_comb begin
    cfg_in.long_char = frame_mode[1];
    cfg_in.two_stop  = frame_mode[0];
    cfg_in.par_off   = parity_mode[2];
    cfg_in.par_sel   = parity_mode[1:0];
    cfg_in.brk       = break_en;
  end

  assign in_ready = ~busy;
  assign accept   = in_valid & in_ready;

  aft_cfg_capture u_cap (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .cfg_in(cfg_in), .data_in(in_data), .cfg_q(cfg_q), .data_q(data_q)
  );

  aft_frame_build u_build (
    .cfg(cfg_q), .data(data_q), .slots(slots), .nslots(nslots)
  );

  aft_bit_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .tick(bit_tick),
    .slots(slots), .nslots(nslots), .busy(busy), .sending(sending), .tx(tx)
  );

endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk
  import async_frame_tx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic       accept,
  input logic       busy,
  input logic       sending,
  input logic       tx,
  input frame_cfg_t cfg_q
);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R12
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx);

  // R9
  tx_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx != $past(tx)) |-> $past(bit_tick));

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sending) |-> !tx);

  // R8
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && cfg_q.brk) |-> !tx);

  // R11
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cfg_q));

endmodule

bind async_frame_tx async_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .accept(accept),
  .busy(busy), .sending(sending), .tx(tx), .cfg_q(cfg_q)
);

// File: tb/async_frame_tx_bench.sv
`timescale 1ns/1ps
module async_frame_tx_bench;

  localparam int TICK_DIV = 3;
  localparam int WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic [1:0] frame_mode = '0;
  logic [2:0] parity_mode = '0;
  logic       break_en = 1'b0;
  logic       in_ready, busy, tx;

  int n_checks = 0;
  int n_fail = 0;
  int n_sent = 0;
  int n_done = 0;

  typedef struct {
    logic [15:0] bits;
    int          len;
    string       tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  async_frame_tx u_async_frame_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .frame_mode(frame_mode),
    .parity_mode(parity_mode), .break_en(break_en), .busy(busy), .tx(tx)
  );

  // tick generator, changes on falling edges
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      cnt = (cnt == TICK_DIV - 1) ? 0 : cnt + 1;
      bit_tick = rst_n && (cnt == 0);
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // expected slot sequence worked out from the requirements
  function automatic exp_t make_exp(logic [7:0] d, logic [1:0] m, logic [2:0] p, logic b, string tag);
    exp_t e;
    int nchar, ones;
    logic pb;
    e.bits = '0;
    e.len = 0;
    e.tag = tag;
    nchar = m[1] ? 8 : 7;
    ones = 0;
    e.bits[e.len] = 1'b0; e.len++;
    for (int i = 0; i < nchar; i++) begin
      e.bits[e.len] = d[i]; e.len++;
      if (d[i]) ones++;
    end
    if (!p[2]) begin
      case (p[1:0])
        2'b00: pb = 1'b0;
        2'b01: pb = 1'b1;
        2'b10: pb = (ones % 2 == 0);
        default: pb = (ones % 2 == 1);
      endcase
      e.bits[e.len] = pb; e.len++;
    end
    for (int i = 0; i < (m[0] ? 2 : 1); i++) begin
      e.bits[e.len] = 1'b1; e.len++;
    end
    if (b) e.bits = '0;
    return e;
  endfunction

  task automatic send(logic [7:0] d, logic [1:0] m, logic [2:0] p, logic b, string tag);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_data = d; frame_mode = m; parity_mode = p; break_en = b; in_valid = 1'b1;
    expq.push_back(make_exp(d, m, p, b, tag));
    n_sent++;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(busy === 1'b1 && in_ready === 1'b0, "R10", "busy after accept", int'(busy), 1);
    // R11: scramble every setting while the frame is in flight
    in_data = ~d; frame_mode = ~m; parity_mode = ~p; break_en = ~b;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && busy && expq.size() != 0) begin
        exp_t e;
        e = expq.pop_front();
        do @(posedge clk); while (!bit_tick);
        for (int i = 0; i < e.len; i++) begin
          bit ok = 1'b1;
          int seen = 0;
          do begin
            @(negedge clk);
            if (tx !== e.bits[i] || busy !== 1'b1) begin
              ok = 1'b0;
              seen = int'(tx);
            end
            @(posedge clk);
          end while (!bit_tick);
          check(ok, e.tag, $sformatf("R9 slot %0d held for one tick", i), seen, int'(e.bits[i]));
        end
        @(negedge clk);
        check(busy === 1'b0 && tx === 1'b1, "R12", "line high and idle after last stop",
              int'({busy, tx}), 1);
        n_done++;
      end
    end
  end

  initial begin
    logic [7:0] pats[5];
    string ptag;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h80; pats[4] = 8'h3C;
    repeat (4) @(negedge clk);
    check(tx === 1'b1 && busy === 1'b0, "R2", "reset idle line", int'({busy, tx}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R10", "ready out of reset", int'(in_ready), 1);
    for (int m = 0; m < 4; m++) begin
      for (int pi = 0; pi < 5; pi++) begin
        logic [2:0] p;
        p = (pi == 4) ? 3'b100 : 3'(pi);
        if (pi == 4) ptag = "R4";
        else if (pi < 2) ptag = "R5";
        else if (pi == 2) ptag = "R6";
        else ptag = "R7";
        for (int k = 0; k < 5; k++) begin
          string t;
          t = $sformatf("R1 R2 R11 %s%s", ptag, (m < 2 && pats[k][7]) ? " R3" : "");
          send(pats[k], 2'(m), p, 1'b0, t);
        end
      end
    end
    send(8'h5A, 2'b11, 3'b010, 1'b1, "R8 long");
    send(8'hFF, 2'b00, 3'b100, 1'b1, "R8 short");
    send(8'h81, 2'b01, 3'b011, 1'b1, "R8 mid");
    send(8'hC3, 2'b10, 3'b101, 1'b0, "R4 R11");
    while (n_done != n_sent) @(negedge clk);
    repeat (5) @(negedge clk);
    check(tx === 1'b1 && in_ready === 1'b1, "R12", "final idle", int'({in_ready, tx}), 3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, n_sent);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule